// File: doc/BRIEF.md
# XTS Data-Unit Formatter

This block surrounds a single 16- or 32-byte line write with the framing that a 128-byte XTS data unit needs. From a 24-bit physical address and a line of plaintext, it builds a zero-filled data unit with the line placed at its offset. It reverses the byte order of the whole unit and derives the starting tweak from the address rounded down to a 128-byte boundary. It then drives an external single-block encryptor through a request/response handshake. The tweak is encrypted first. After that, each of the eight 16-byte blocks is XORed with the running tweak before and after the cipher, and the tweak is doubled in GF(2^128) between blocks.

When the last block returns, the block restores the original byte order and cuts out the line-sized ciphertext from the same offset. It then raises a one-cycle done pulse. The ciphertext stays on its output until the next operation starts.

A line write with a 128-byte-aligned address and a small line gives, in the ciphertext, the first 16 bytes of the reversed-back unit. A line with its offset near the end of the unit gets only the bytes that still fall inside the unit.

Top module: `xtsdu_formatter`

## Requirements
- R1: The first encryptor request of an operation has `enc_tweak_key_o` = 1. Its block value is zero everywhere except bits [23:0], which hold the address with its low 7 bits cleared. Byte 0 of any 128-bit block is bits [7:0].
- R2: Plaintext byte k is `plain_i[8k+7:8k]`. The unit byte U[p] is plaintext byte ((addr mod 32) + p - (addr mod 128)) mod 32 when p - (addr mod 128) is in the range 0 to L-1, and zero otherwise. L = 16 when `line_sel_i` = 0 and L = 32 when `line_sel_i` = 1.
- R3: The cipher-domain unit is R[j] = U[127-j]. Block b is made of R[16b] through R[16b+15]. Request b+1 (for b = 0 to 7) carries `enc_tweak_key_o` = 0 and the value block_b XOR T_b, where T_0 is the encryptor's answer to the first request.
- R4: T_{b+1} = (T_b shifted left by one) XOR (0x87 if bit 127 of T_b is set, else 0).
- R5: C_b = (response to request b+1) XOR T_b. The reversed-back result is O[j] = C[127-j]. Ciphertext byte i is O[(addr mod 128) + i] for i < L when that index is below 128, and zero otherwise. In particular, bytes 16 to 31 are zero for a 16-byte line.
- R6: `enc_start_o` is high for exactly one cycle per request. Each operation issues exactly nine requests. A response pulse on `enc_done_i` is taken only while a request is outstanding, and a response pulse at any other time has no effect.
- R7: `done_o` is a single-cycle pulse in the cycle after the last response is taken. `cipher_o` is valid from that cycle and holds until the next accepted start.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its address, line size and plaintext and issues no extra requests.
- R9: After reset, `busy_o`, `done_o` and `enc_start_o` are 0 and `cipher_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| addr_i | input | 24 | Physical address of the line |
| line_sel_i | input | 1 | Line size: 0 = 16 bytes, 1 = 32 bytes |
| plain_i | input | 256 | Plaintext register contents, byte k at bits 8k+7:8k |
| enc_start_o | output | 1 | Single-cycle request to the block encryptor |
| enc_tweak_key_o | output | 1 | Request uses the tweak key (1) or the data key (0) |
| enc_block_o | output | 128 | Block handed to the encryptor |
| enc_done_i | input | 1 | Encryptor response pulse |
| enc_result_i | input | 128 | Encryptor output block, valid with enc_done_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| cipher_o | output | 256 | Extracted ciphertext line, unused bytes zero |

## Verification
Assertions check several properties on every cycle:
- request pulses last one cycle;
- the first request of each operation uses the tweak key;
- busy stays high until done, which ignores any stray start;
- done pulses once, right after a response;
- the upper half of the ciphertext stays zero for a 16-byte line.

Only the bench can show that the data is correct. It checks the placement of the line within the unit, the byte reversal in both directions, the masked tweak and its doubling across blocks, and the extracted bytes. It does this by comparing every request block and the final line against an independent byte-level model, using a simple encryptor stand-in. The bench scenarios also cover several other cases:
- different response latencies;
- wrapped plaintext offsets and lines that run past the end of the unit;
- starts arriving mid-operation;
- spurious responses.

// File: rtl/xtsdu_pkg.sv
`timescale 1ns/1ps
package xtsdu_pkg;

   localparam int BLK_W     = 128;
   localparam int BLK_BYTES = BLK_W / 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TWK_REQ,
      ST_TWK_WAIT,
      ST_BLK_REQ,
      ST_BLK_WAIT,
      ST_FIN
   } walk_st_e;

   // multiply by x in GF(2^128), reduction polynomial x^128+x^7+x^2+x+1
   function automatic logic [BLK_W-1:0] gf_mul_x(input logic [BLK_W-1:0] t);
      logic [BLK_W-1:0] r;
      r = {t[BLK_W-2:0], 1'b0};
      if (t[BLK_W-1]) r[7:0] = r[7:0] ^ 8'h87;
      return r;
   endfunction

endpackage

// File: rtl/xtsdu_pack.sv
`timescale 1ns/1ps
module xtsdu_pack #(
   parameter int ADDR_W         = 24,
   parameter int UNIT_BYTES     = 128,
   parameter int LINE_MAX_BYTES = 32,
   parameter bit BYTE_REVERSE   = 1'b1
) (
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic                        line_sel_i,
   input  logic [LINE_MAX_BYTES*8-1:0] plain_i,
   output logic [xtsdu_pkg::BLK_W-1:0] tweak_o,
   output logic [UNIT_BYTES*8-1:0]     unit_o
);
   localparam int PAD_W  = $clog2(UNIT_BYTES);
   localparam int OFF_W  = $clog2(LINE_MAX_BYTES);
   localparam int TW_PAD = xtsdu_pkg::BLK_W - ADDR_W;

   logic [PAD_W-1:0]          pad;
   logic [OFF_W-1:0]          poff;
   logic [PAD_W:0]            line_len;
   logic [PAD_W-1:0]          rel;
   logic [OFF_W-1:0]          src;
   logic [UNIT_BYTES*8-1:0]   unit_plain;

   assign pad      = addr_i[PAD_W-1:0];
   assign poff     = addr_i[OFF_W-1:0];
   assign line_len = line_sel_i ? (PAD_W+1)'(LINE_MAX_BYTES)
                                : (PAD_W+1)'(LINE_MAX_BYTES/2);

   // tweak seed: address rounded down to the unit boundary, zero above
   assign tweak_o = {{TW_PAD{1'b0}}, addr_i[ADDR_W-1:PAD_W], {PAD_W{1'b0}}};

   // place the line inside a zero unit, source index wraps in the line regs
   always_comb begin
      unit_plain = '0;
      rel        = '0;
      src        = '0;
      for (int p = 0; p < UNIT_BYTES; p++) begin
         rel = PAD_W'(p) - pad;
         src = poff + OFF_W'(rel);
         if ((PAD_W'(p) >= pad) && ({1'b0, rel} < line_len))
            unit_plain[8*p +: 8] = plain_i[{src, 3'b000} +: 8];
      end
   end

   generate
      if (BYTE_REVERSE) begin : g_rev
         for (genvar g = 0; g < UNIT_BYTES; g++) begin : g_byte
            assign unit_o[8*g +: 8] = unit_plain[8*(UNIT_BYTES-1-g) +: 8];
         end
      end else begin : g_fwd
         assign unit_o = unit_plain;
      end
   endgenerate

endmodule

// File: rtl/xtsdu_walker.sv
`timescale 1ns/1ps
module xtsdu_walker
   import xtsdu_pkg::*;
#(
   parameter int UNIT_BYTES = 128
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    start_i,
   input  logic [UNIT_BYTES*8-1:0] unit_i,
   input  logic [BLK_W-1:0]        tweak_seed_i,
   input  logic                    enc_done_i,
   input  logic [BLK_W-1:0]        enc_result_i,
   output logic                    enc_start_o,
   output logic                    enc_tweak_key_o,
   output logic [BLK_W-1:0]        enc_block_o,
   output logic                    busy_o,
   output logic                    done_o,
   output logic [UNIT_BYTES*8-1:0] result_o
);
   localparam int NBLK  = UNIT_BYTES / BLK_BYTES;
   localparam int IDX_W = $clog2(NBLK);

   walk_st_e                st_q;
   logic [IDX_W-1:0]        idx_q;
   logic [BLK_W-1:0]        twk_q;
   logic [UNIT_BYTES*8-1:0] unit_q;
   logic [UNIT_BYTES*8-1:0] res_q;
   logic [BLK_W-1:0]        cur_blk;

   assign cur_blk = unit_q[{idx_q, 7'b0000000} +: BLK_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         twk_q  <= '0;
         unit_q <= '0;
         res_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               unit_q <= unit_i;
               twk_q  <= tweak_seed_i;
               idx_q  <= '0;
               st_q   <= ST_TWK_REQ;
            end
            ST_TWK_REQ: st_q <= ST_TWK_WAIT;
            ST_TWK_WAIT: if (enc_done_i) begin
               twk_q <= enc_result_i;
               st_q  <= ST_BLK_REQ;
            end
            ST_BLK_REQ: st_q <= ST_BLK_WAIT;
            ST_BLK_WAIT: if (enc_done_i) begin
               res_q[{idx_q, 7'b0000000} +: BLK_W] <= enc_result_i ^ twk_q;
               twk_q <= gf_mul_x(twk_q);
               if (idx_q == IDX_W'(NBLK-1)) begin
                  st_q <= ST_FIN;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= ST_BLK_REQ;
               end
            end
            ST_FIN: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign enc_start_o     = (st_q == ST_TWK_REQ) || (st_q == ST_BLK_REQ);
   assign enc_tweak_key_o = (st_q == ST_TWK_REQ);
   assign enc_block_o     = (st_q == ST_TWK_REQ) ? twk_q : (cur_blk ^ twk_q);
   assign busy_o          = (st_q != ST_IDLE);
   assign done_o          = (st_q == ST_FIN);
   assign result_o        = res_q;

   // R6: every request lasts a single cycle
   p_req_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enc_start_o |=> !enc_start_o);

   // R1: an operation opens with a tweak-key request
   p_first_req_tweak_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> (enc_start_o && enc_tweak_key_o));

   // R7: completion follows a taken response and lasts one cycle
   p_done_after_resp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $past(enc_done_i));
   p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R8: once running, the walk only ends through done
   p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !done_o) |=> busy_o);

endmodule

// File: rtl/xtsdu_unpack.sv
`timescale 1ns/1ps
module xtsdu_unpack #(
   parameter int UNIT_BYTES     = 128,
   parameter int LINE_MAX_BYTES = 32,
   parameter bit BYTE_REVERSE   = 1'b1
) (
   input  logic [UNIT_BYTES*8-1:0]       result_i,
   input  logic [$clog2(UNIT_BYTES)-1:0] pad_i,
   input  logic                          line_sel_i,
   output logic [LINE_MAX_BYTES*8-1:0]   cipher_o
);
   localparam int PAD_W = $clog2(UNIT_BYTES);

   logic [UNIT_BYTES*8-1:0] natural_q;
   logic [PAD_W:0]          line_len;
   logic [PAD_W:0]          pos;

   generate
      if (BYTE_REVERSE) begin : g_rev
         for (genvar g = 0; g < UNIT_BYTES; g++) begin : g_byte
            assign natural_q[8*g +: 8] = result_i[8*(UNIT_BYTES-1-g) +: 8];
         end
      end else begin : g_fwd
         assign natural_q = result_i;
      end
   endgenerate

   assign line_len = line_sel_i ? (PAD_W+1)'(LINE_MAX_BYTES)
                                : (PAD_W+1)'(LINE_MAX_BYTES/2);

   always_comb begin
      cipher_o = '0;
      pos      = '0;
      for (int i = 0; i < LINE_MAX_BYTES; i++) begin
         pos = {1'b0, pad_i} + (PAD_W+1)'(i);
         if (((PAD_W+1)'(i) < line_len) && (pos < (PAD_W+1)'(UNIT_BYTES)))
            cipher_o[8*i +: 8] = natural_q[{pos[PAD_W-1:0], 3'b000} +: 8];
      end
   end

endmodule

// File: rtl/xtsdu_formatter.sv
`timescale 1ns/1ps
module xtsdu_formatter #(
   parameter int ADDR_W         = 24,
   parameter int UNIT_BYTES     = 128,
   parameter int LINE_MAX_BYTES = 32,
   parameter bit BYTE_REVERSE   = 1'b1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        start_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic                        line_sel_i,
   input  logic [LINE_MAX_BYTES*8-1:0] plain_i,
   output logic                        enc_start_o,
   output logic                        enc_tweak_key_o,
   output logic [127:0]                enc_block_o,
   input  logic                        enc_done_i,
   input  logic [127:0]                enc_result_i,
   output logic                        busy_o,
   output logic                        done_o,
   output logic [LINE_MAX_BYTES*8-1:0] cipher_o
);
   localparam int PAD_W  = $clog2(UNIT_BYTES);
   localparam int LINE_W = LINE_MAX_BYTES * 8;

   generate
      if ((UNIT_BYTES & (UNIT_BYTES-1)) != 0 || UNIT_BYTES < 2*xtsdu_pkg::BLK_BYTES) begin : g_bad_unit
         $error("UNIT_BYTES must be a power of two holding at least two blocks");
      end
      if ((LINE_MAX_BYTES & (LINE_MAX_BYTES-1)) != 0 || LINE_MAX_BYTES < 2
          || LINE_MAX_BYTES > UNIT_BYTES) begin : g_bad_line
         $error("LINE_MAX_BYTES must be a power of two no larger than the unit");
      end
      if (ADDR_W <= PAD_W || ADDR_W >= xtsdu_pkg::BLK_W) begin : g_bad_addr
         $error("ADDR_W must exceed the unit offset and fit in a block");
      end
   endgenerate

   logic [127:0]            tweak_seed;
   logic [UNIT_BYTES*8-1:0] unit_rev;
   logic [UNIT_BYTES*8-1:0] result;
   logic [PAD_W-1:0]        pad_q;
   logic                    line_q;

   xtsdu_pack #(
      .ADDR_W(ADDR_W), .UNIT_BYTES(UNIT_BYTES),
      .LINE_MAX_BYTES(LINE_MAX_BYTES), .BYTE_REVERSE(BYTE_REVERSE)
   ) u_pack (
      .addr_i(addr_i), .line_sel_i(line_sel_i), .plain_i(plain_i),
      .tweak_o(tweak_seed), .unit_o(unit_rev)
   );

   xtsdu_walker #(.UNIT_BYTES(UNIT_BYTES)) u_walk (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
      .unit_i(unit_rev), .tweak_seed_i(tweak_seed),
      .enc_done_i(enc_done_i), .enc_result_i(enc_result_i),
      .enc_start_o(enc_start_o), .enc_tweak_key_o(enc_tweak_key_o),
      .enc_block_o(enc_block_o), .busy_o(busy_o), .done_o(done_o),
      .result_o(result)
   );

   // extraction geometry is frozen when an operation is accepted
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pad_q  <= '0;
         line_q <= 1'b0;
      end else if (start_i && !busy_o) begin
         pad_q  <= addr_i[PAD_W-1:0];
         line_q <= line_sel_i;
      end
   end

   xtsdu_unpack #(
      .UNIT_BYTES(UNIT_BYTES), .LINE_MAX_BYTES(LINE_MAX_BYTES),
      .BYTE_REVERSE(BYTE_REVERSE)
   ) u_unpack (
      .result_i(result), .pad_i(pad_q), .line_sel_i(line_q), .cipher_o(cipher_o)
   );

   // R5: a short line never fills the upper half of the output
   p_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line_q |-> (cipher_o[LINE_W-1:LINE_W/2] == '0));

endmodule

// File: tb/xtsdu_formatter_test.sv
`timescale 1ns/1ps
module xtsdu_formatter_test;

   localparam int NVEC = 7;
   // [31:8] address, [7:4] extra response latency, [0] line select
   localparam logic [31:0] VEC [NVEC] = '{
      32'h00000000, 32'h00002021, 32'hFFFFE011, 32'h12347030,
      32'h80004000, 32'h00FF9051, 32'h00007001
   };
   localparam logic [127:0] KT = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
   localparam logic [127:0] KD = 128'h13579bdf_02468ace_fdb97531_eca86420;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [23:0]  addr = '0;
   logic         line_sel = 1'b0;
   logic [255:0] plain = '0;
   logic         enc_start, enc_tweak_key, busy, done;
   logic [127:0] enc_block;
   logic         enc_done = 1'b0, spur_done = 1'b0;
   logic [127:0] enc_result = '0;
   logic [255:0] cipher;

   int n_total = 0, n_fail = 0;
   int resp_lat = 0;
   int req_cnt = 0;
   logic         req_key [16];
   logic [127:0] req_blk [16];
   logic [127:0] exp_req [9];
   logic [255:0] exp_ct;

   always #2.5 clk = ~clk;

   xtsdu_formatter uut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
      .line_sel_i(line_sel), .plain_i(plain),
      .enc_start_o(enc_start), .enc_tweak_key_o(enc_tweak_key),
      .enc_block_o(enc_block), .enc_done_i(enc_done | spur_done),
      .enc_result_i(enc_result), .busy_o(busy), .done_o(done),
      .cipher_o(cipher)
   );

   function automatic logic [127:0] enc_model(input logic k, input logic [127:0] x);
      if (k) return {x[98:0], x[127:99]} ^ KT;
      return {x[114:0], x[127:115]} ^ KD;
   endfunction

   function automatic logic [127:0] dbl(input logic [127:0] t);
      logic [127:0] r;
      r = t << 1;
      if (t[127]) r = r ^ 128'h87;
      return r;
   endfunction

   task automatic model_op(input logic [23:0] a, input logic sel, input logic [255:0] pl);
      logic [1023:0] u, r, c, o;
      logic [127:0]  t, blk;
      int pad, poff, len;
      u = '0; c = '0;
      pad = int'(a[6:0]); poff = int'(a[4:0]); len = sel ? 32 : 16;
      for (int i = 0; i < len; i++)
         if (pad + i < 128) u[8*(pad+i) +: 8] = pl[8*((poff+i)%32) +: 8];
      for (int j = 0; j < 128; j++) r[8*j +: 8] = u[8*(127-j) +: 8];
      exp_req[0] = {104'b0, a[23:7], 7'b0};
      t = enc_model(1'b1, exp_req[0]);
      for (int b = 0; b < 8; b++) begin
         blk = r[128*b +: 128];
         exp_req[b+1] = blk ^ t;
         c[128*b +: 128] = enc_model(1'b0, blk ^ t) ^ t;
         t = dbl(t);
      end
      for (int j = 0; j < 128; j++) o[8*j +: 8] = c[8*(127-j) +: 8];
      exp_ct = '0;
      for (int i = 0; i < len; i++)
         if (pad + i < 128) exp_ct[8*i +: 8] = o[8*(pad+i) +: 8];
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   endtask

   // encryptor stand-in
   initial begin
      forever begin
         @(negedge clk);
         enc_done = 1'b0;
         if (rst_n && enc_start) begin
            logic [127:0] resp;
            if (req_cnt < 16) begin
               req_key[req_cnt] = enc_tweak_key;
               req_blk[req_cnt] = enc_block;
            end
            req_cnt++;
            resp = enc_model(enc_tweak_key, enc_block);
            repeat (1 + resp_lat) @(negedge clk);
            enc_done   = 1'b1;
            enc_result = resp;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_total++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   task automatic pattern(input int v, output logic [255:0] pl);
      for (int k = 0; k < 32; k++) pl[8*k +: 8] = 8'((k*37 + v*11 + 5) & 255);
   endtask

   task automatic kick(input logic [23:0] a, input logic s, input logic [255:0] pl);
      @(negedge clk);
      addr = a; line_sel = s; plain = pl; req_cnt = 0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int c = 0; c < 3000; c++) begin
         if (done) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic check_result(input string tag);
      bit reqs_ok;
      chk(req_cnt == 9, "R6", {tag, " request count"}, 256'(req_cnt), 256'd9);
      chk(req_key[0] == 1'b1 && req_blk[0] == exp_req[0], "R1",
          {tag, " tweak request"}, {128'(req_key[0]), req_blk[0]}, {128'd1, exp_req[0]});
      reqs_ok = 1'b1;
      for (int b = 1; b < 9; b++)
         if (req_key[b] != 1'b0 || req_blk[b] != exp_req[b]) reqs_ok = 1'b0;
      chk(reqs_ok, "R3 R4", {tag, " block requests"}, 256'(req_blk[2]), 256'(exp_req[2]));
      chk(cipher == exp_ct, "R2 R5", {tag, " ciphertext"}, cipher, exp_ct);
   endtask

   initial begin
      bit seen;
      logic [255:0] pl, pl2, held;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(!busy && !done && !enc_start, "R9", "control outputs after reset",
          {253'b0, busy, done, enc_start}, 256'd0);
      chk(cipher == '0, "R9", "ciphertext after reset", cipher, 256'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !enc_start && cipher == '0, "R9", "idle after release",
          {253'b0, busy, done, enc_start}, 256'd0);

      // table of operations
      for (int v = 0; v < NVEC; v++) begin
         resp_lat = int'(VEC[v][7:4]);
         pattern(v, pl);
         model_op(VEC[v][31:8], VEC[v][0], pl);
         kick(VEC[v][31:8], VEC[v][0], pl);
         wait_done(seen);
         chk(seen, "R7", $sformatf("vector %0d done", v), 256'(seen), 256'd1);
         check_result($sformatf("vector %0d", v));
         @(negedge clk);
         chk(!done, "R7", $sformatf("vector %0d done width", v), 256'(done), 256'd0);
      end

      // R7 ciphertext holds while idle
      held = cipher;
      repeat (6) @(negedge clk);
      chk(cipher == held && !busy, "R7", "ciphertext held", cipher, held);

      // R6 spurious response while idle has no effect
      spur_done = 1'b1; enc_result = '1;
      @(negedge clk);
      spur_done = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && cipher == held, "R6", "spurious response ignored",
          cipher, held);

      // R8 start while busy is ignored
      resp_lat = 2;
      pattern(20, pl);
      pattern(21, pl2);
      model_op(24'h3C5A40, 1'b1, pl);
      kick(24'h3C5A40, 1'b1, pl);
      while (req_cnt < 3) @(negedge clk);
      addr = 24'h000010; line_sel = 1'b0; plain = pl2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(seen);
      chk(seen, "R8", "busy run completes", 256'(seen), 256'd1);
      check_result("R8 busy start");
      repeat (4) @(negedge clk);
      chk(req_cnt == 9 && !busy, "R8", "no extra requests", 256'(req_cnt), 256'd9);

      // R9 reset mid-operation returns to the reset state
      kick(24'h000080, 1'b0, pl);
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && !done && !enc_start && cipher == '0, "R9", "reset mid-operation",
          cipher, 256'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule